// File: doc/BRIEF.md
# Instruction Control Decoder

This block sits between the instruction register and the datapath of a simple single-cycle load/store processor. It takes the 6-bit opcode of the instruction being executed, the zero flag from the register-file operand test, and a pending interrupt request. From these it produces every steering and strobe signal the datapath needs for that cycle. It is purely combinational: the opcode, flag and request go in, and the control word comes out in the same cycle.

The opcode is first sorted into an instruction class. Register-register operations use top bits `10` and register-literal operations use top bits `11`. Loads, stores, the PC-relative load, the jump and the zero branch each have one fixed code. Every other code is an illegal instruction. Each class then maps to a control word. A last stage replaces that word with an exception-entry word when the opcode is illegal or an interrupt is pending. The exception-entry word saves the return address in the exception-pointer register and suppresses any memory write. An interrupt takes precedence over every other outcome.

Top module: `ctl_decoder`

## Requirements
- R1: An opcode whose top two bits are `10` gives pc_sel 0 (PC+4), wd_sel 1 (ALU result), b_sel 0 (register operand), alu_fn equal to opcode bits [3:0], rf_we 1, mem_we 0, a_sel 0, ra2_sel 0 and xp_sel 0.
- R2: An opcode whose top two bits are `11` behaves as in R1, except that b_sel is 1 (sign-extended literal).
- R3: Opcode `011000` (load) gives b_sel 1, alu_fn `0000` (add), wd_sel 2 (memory read data), rf_we 1, mem_we 0 and pc_sel 0.
- R4: Opcode `011001` (store) gives mem_we 1, rf_we 0, ra2_sel 1 (read rc), b_sel 1, alu_fn `0000` and pc_sel 0.
- R5: Opcode `011111` (PC-relative load) gives a_sel 1, wd_sel 2, alu_fn `0000`, b_sel 0, rf_we 1, mem_we 0 and pc_sel 0.
- R6: Opcode `011011` (jump) gives pc_sel 2 (jump target), wd_sel 0 (PC+4), rf_we 1 and mem_we 0.
- R7: Opcode `011100` (branch on zero) gives wd_sel 0, rf_we 1 and mem_we 0. It gives pc_sel 1 (branch target) when zero_i is 1 and pc_sel 0 when zero_i is 0.
- R8: Any opcode not listed in R1 to R7 gives pc_sel 3 (illegal-opcode vector), xp_sel 1 (exception pointer), wd_sel 0, rf_we 1 and mem_we 0. All other outputs are 0.
- R9: When irq_i is 1, the outputs are pc_sel 4 (interrupt vector), xp_sel 1, wd_sel 0, rf_we 1 and mem_we 0, with all other outputs 0. This holds for every opcode and both zero_i values.
- R10: zero_i has no effect on any output except pc_sel for the branch opcode of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Opcode field of the current instruction |
| zero_i | input | 1 | Operand-is-zero flag from the datapath |
| irq_i | input | 1 | Pending interrupt request |
| pc_sel_o | output | 3 | Next-PC source: 0 PC+4, 1 branch, 2 jump, 3 illegal vector, 4 interrupt vector |
| ra2_sel_o | output | 1 | Second read port address: 0 rb, 1 rc |
| a_sel_o | output | 1 | ALU A input: 0 register, 1 PC-relative address |
| b_sel_o | output | 1 | ALU B input: 0 register, 1 sign-extended literal |
| wd_sel_o | output | 2 | Write-back source: 0 PC+4, 1 ALU, 2 memory |
| alu_fn_o | output | 4 | ALU function code |
| xp_sel_o | output | 1 | Write address: 0 rc, 1 exception pointer |
| mem_we_o | output | 1 | Data-memory write strobe |
| rf_we_o | output | 1 | Register-file write enable |

## Verification
Every output is a pure function of the current inputs, so each result is due in the same cycle its stimulus is applied, with no register on the path. The driver changes the inputs on the falling clock edge and queues the expected control word. The monitor pops that word on the next rising edge, half a period later, when the combinational outputs have settled. All 64 opcodes are swept against both zero-flag values and both interrupt values, so each fixed code, every operate code and every illegal code is compared in full.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int OP_W     = 6;
  localparam int ALUFN_W  = OP_W - 2;
  localparam int PCSEL_W  = 3;
  localparam int WDSEL_W  = 2;

  // fixed opcodes
  localparam logic [OP_W-1:0] OPC_LD  = 6'b011000;
  localparam logic [OP_W-1:0] OPC_ST  = 6'b011001;
  localparam logic [OP_W-1:0] OPC_JMP = 6'b011011;
  localparam logic [OP_W-1:0] OPC_BEQ = 6'b011100;
  localparam logic [OP_W-1:0] OPC_LDR = 6'b011111;

  // next-PC sources
  localparam logic [PCSEL_W-1:0] PC_INC = 3'd0;
  localparam logic [PCSEL_W-1:0] PC_BR  = 3'd1;
  localparam logic [PCSEL_W-1:0] PC_JT  = 3'd2;
  localparam logic [PCSEL_W-1:0] PC_ILL = 3'd3;
  localparam logic [PCSEL_W-1:0] PC_IRQ = 3'd4;

  // write-back sources
  localparam logic [WDSEL_W-1:0] WD_PC  = 2'd0;
  localparam logic [WDSEL_W-1:0] WD_ALU = 2'd1;
  localparam logic [WDSEL_W-1:0] WD_MEM = 2'd2;

  localparam logic [ALUFN_W-1:0] FN_ADD = '0;

  typedef enum logic [2:0] {
    CL_OPRR, CL_OPLIT, CL_LD, CL_ST, CL_LDR, CL_JMP, CL_BEQ, CL_ILL
  } iclass_t;

  typedef struct packed {
    logic [PCSEL_W-1:0] pc_sel;
    logic               ra2_sel;
    logic               a_sel;
    logic               b_sel;
    logic [WDSEL_W-1:0] wd_sel;
    logic [ALUFN_W-1:0] alu_fn;
    logic               xp_sel;
    logic               mem_we;
    logic               rf_we;
  } ctl_t;

  function automatic iclass_t classify(logic [OP_W-1:0] op);
    iclass_t c;
    if (op[OP_W-1])            c = op[OP_W-2] ? CL_OPLIT : CL_OPRR;
    else if (op == OPC_LD)     c = CL_LD;
    else if (op == OPC_ST)     c = CL_ST;
    else if (op == OPC_LDR)    c = CL_LDR;
    else if (op == OPC_JMP)    c = CL_JMP;
    else if (op == OPC_BEQ)    c = CL_BEQ;
    else                       c = CL_ILL;
    return c;
  endfunction

  // control word used on exception entry: save PC+4 in the exception pointer
  function automatic ctl_t trap_word(logic [PCSEL_W-1:0] vec);
    ctl_t t;
    t        = '0;
    t.pc_sel = vec;
    t.xp_sel = 1'b1;
    t.wd_sel = WD_PC;
    t.rf_we  = 1'b1;
    return t;
  endfunction
endpackage

// File: rtl/ctl_class_decode.sv
module ctl_class_decode
  import ctl_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output iclass_t         cls_o,
  output logic            illegal_o
);
  assign cls_o     = classify(op_i);
  assign illegal_o = (cls_o == CL_ILL);
endmodule

// File: rtl/ctl_field_gen.sv
module ctl_field_gen
  import ctl_pkg::*;
(
  input  iclass_t            cls_i,
  input  logic [ALUFN_W-1:0] op_lo_i,
  input  logic               zero_i,
  output ctl_t               ctl_o
);
  always_comb begin
    ctl_o = '0;
    unique case (cls_i)
      CL_OPRR, CL_OPLIT: begin
        ctl_o.alu_fn = op_lo_i;
        ctl_o.b_sel  = (cls_i == CL_OPLIT);
        ctl_o.wd_sel = WD_ALU;
        ctl_o.rf_we  = 1'b1;
      end
      CL_LD: begin
        ctl_o.b_sel  = 1'b1;
        ctl_o.alu_fn = FN_ADD;
        ctl_o.wd_sel = WD_MEM;
        ctl_o.rf_we  = 1'b1;
      end
      CL_ST: begin
        ctl_o.b_sel   = 1'b1;
        ctl_o.ra2_sel = 1'b1;
        ctl_o.alu_fn  = FN_ADD;
        ctl_o.mem_we  = 1'b1;
      end
      CL_LDR: begin
        ctl_o.a_sel  = 1'b1;
        ctl_o.alu_fn = FN_ADD;
        ctl_o.wd_sel = WD_MEM;
        ctl_o.rf_we  = 1'b1;
      end
      CL_JMP: begin
        ctl_o.pc_sel = PC_JT;
        ctl_o.wd_sel = WD_PC;
        ctl_o.rf_we  = 1'b1;
      end
      CL_BEQ: begin
        ctl_o.pc_sel = zero_i ? PC_BR : PC_INC;
        ctl_o.wd_sel = WD_PC;
        ctl_o.rf_we  = 1'b1;
      end
      default: ctl_o = trap_word(PC_ILL);
    endcase
  end
endmodule

// File: rtl/ctl_exc_override.sv
module ctl_exc_override
  import ctl_pkg::*;
(
  input  logic irq_i,
  input  logic illegal_i,
  input  ctl_t normal_i,
  output ctl_t ctl_o
);
  always_comb begin
    if (irq_i)          ctl_o = trap_word(PC_IRQ);
    else if (illegal_i) ctl_o = trap_word(PC_ILL);
    else                ctl_o = normal_i;
  end
endmodule

// File: rtl/ctl_decoder.sv
module ctl_decoder
  import ctl_pkg::*;
(
  input  logic [OP_W-1:0]    op_i,
  input  logic               zero_i,
  input  logic               irq_i,
  output logic [PCSEL_W-1:0] pc_sel_o,
  output logic               ra2_sel_o,
  output logic               a_sel_o,
  output logic               b_sel_o,
  output logic [WDSEL_W-1:0] wd_sel_o,
  output logic [ALUFN_W-1:0] alu_fn_o,
  output logic               xp_sel_o,
  output logic               mem_we_o,
  output logic               rf_we_o
);
  iclass_t cls;
  logic    illegal;
  ctl_t    normal_ctl;
  ctl_t    final_ctl;

  ctl_class_decode u_cls (
    .op_i      (op_i),
    .cls_o     (cls),
    .illegal_o (illegal)
  );

  ctl_field_gen u_fields (
    .cls_i   (cls),
    .op_lo_i (op_i[ALUFN_W-1:0]),
    .zero_i  (zero_i),
    .ctl_o   (normal_ctl)
  );

  ctl_exc_override u_exc (
    .irq_i     (irq_i),
    .illegal_i (illegal),
    .normal_i  (normal_ctl),
    .ctl_o     (final_ctl)
  );

  assign pc_sel_o  = final_ctl.pc_sel;
  assign ra2_sel_o = final_ctl.ra2_sel;
  assign a_sel_o   = final_ctl.a_sel;
  assign b_sel_o   = final_ctl.b_sel;
  assign wd_sel_o  = final_ctl.wd_sel;
  assign alu_fn_o  = final_ctl.alu_fn;
  assign xp_sel_o  = final_ctl.xp_sel;
  assign mem_we_o  = final_ctl.mem_we;
  assign rf_we_o   = final_ctl.rf_we;

  always_comb begin
    // R9
    irq_entry_chk: assert (!irq_i || (pc_sel_o == PC_IRQ && xp_sel_o && !mem_we_o))
      else $error("interrupt not taken");
    // R8
    illegal_entry_chk: assert (irq_i || !illegal || (pc_sel_o == PC_ILL && xp_sel_o && !mem_we_o))
      else $error("illegal opcode not trapped");
    // R4
    store_no_rf_write_chk: assert (!mem_we_o || (!rf_we_o && ra2_sel_o && !irq_i))
      else $error("memory write with register write");
    // R7
    branch_needs_zero_chk: assert (pc_sel_o != PC_BR || (zero_i && op_i == OPC_BEQ))
      else $error("branch taken without zero flag");
    // R5
    pcrel_reads_mem_chk: assert (!a_sel_o || wd_sel_o == WD_MEM)
      else $error("PC-relative operand without memory write-back");
  end
endmodule

// File: tb/ctl_decoder_tb.sv
`timescale 1ns/1ps
module ctl_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [5:0] op;
  logic       zero, irq;
  logic [2:0] pc_sel;
  logic       ra2_sel, a_sel, b_sel, xp_sel, mem_we, rf_we;
  logic [1:0] wd_sel;
  logic [3:0] alu_fn;

  ctl_decoder u_dut (
    .op_i(op), .zero_i(zero), .irq_i(irq),
    .pc_sel_o(pc_sel), .ra2_sel_o(ra2_sel), .a_sel_o(a_sel), .b_sel_o(b_sel),
    .wd_sel_o(wd_sel), .alu_fn_o(alu_fn), .xp_sel_o(xp_sel),
    .mem_we_o(mem_we), .rf_we_o(rf_we)
  );

  typedef struct {
    logic [15:0] word;
    string       tag;
    logic [5:0]  op;
    logic        z;
    logic        q;
  } item_t;

  item_t queue_q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // packs {pc,ra2,a,b,wd,fn,xp,we,rfwe}
  function automatic logic [15:0] pack(logic [2:0] p, logic r2, logic a, logic b,
                                       logic [1:0] w, logic [3:0] f, logic x,
                                       logic m, logic rf);
    return {p, r2, a, b, w, f, x, m, rf};
  endfunction

  function automatic item_t model(logic [5:0] o, logic z, logic q);
    item_t it;
    it.op = o; it.z = z; it.q = q;
    if (q) begin
      it.word = pack(3'd4, 0, 0, 0, 2'd0, 4'd0, 1, 0, 1); it.tag = "R9";
    end else if (o[5:4] == 2'b10) begin
      it.word = pack(3'd0, 0, 0, 0, 2'd1, o[3:0], 0, 0, 1); it.tag = "R1";
    end else if (o[5:4] == 2'b11) begin
      it.word = pack(3'd0, 0, 0, 1, 2'd1, o[3:0], 0, 0, 1); it.tag = "R2";
    end else begin
      case (o)
        6'h18: begin it.word = pack(3'd0, 0, 0, 1, 2'd2, 4'd0, 0, 0, 1); it.tag = "R3"; end
        6'h19: begin it.word = pack(3'd0, 1, 0, 1, 2'd0, 4'd0, 0, 1, 0); it.tag = "R4"; end
        6'h1F: begin it.word = pack(3'd0, 0, 1, 0, 2'd2, 4'd0, 0, 0, 1); it.tag = "R5"; end
        6'h1B: begin it.word = pack(3'd2, 0, 0, 0, 2'd0, 4'd0, 0, 0, 1); it.tag = "R6"; end
        6'h1C: begin it.word = pack(z ? 3'd1 : 3'd0, 0, 0, 0, 2'd0, 4'd0, 0, 0, 1); it.tag = "R7"; end
        default: begin it.word = pack(3'd3, 0, 0, 0, 2'd0, 4'd0, 1, 0, 1); it.tag = "R8"; end
      endcase
    end
    if (!q && z && o != 6'h1C) it.tag = {it.tag, "/R10"};
    return it;
  endfunction

  task automatic drive(logic [5:0] o, logic z, logic q);
    @(negedge clk);
    op = o; zero = z; irq = q;
    queue_q.push_back(model(o, z, q));
  endtask

  // monitor: results are combinational, due half a period after the falling-edge drive
  always @(posedge clk) begin
    if (queue_q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it  = queue_q.pop_front();
      act = pack(pc_sel, ra2_sel, a_sel, b_sel, wd_sel, alu_fn, xp_sel, mem_we, rf_we);
      checks++;
      if (act !== it.word) begin
        fails++;
        $display("FAIL %s op=%b z=%0b irq=%0b actual=%h expected=%h",
                 it.tag, it.op, it.z, it.q, act, it.word);
      end
    end
  end

  initial begin
    op = 6'd0; zero = 1'b0; irq = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // first check: state out of reset, opcode 0 is illegal (R8)
    drive(6'd0, 1'b0, 1'b0);
    // R7 both flag values, then R9 overriding a store with a taken branch setup
    drive(6'h1C, 1'b1, 1'b0);
    drive(6'h1C, 1'b0, 1'b0);
    drive(6'h19, 1'b1, 1'b1);
    // full sweep: every opcode, both zero values, both interrupt values
    for (int q = 0; q < 2; q++)
      for (int z = 0; z < 2; z++)
        for (int o = 0; o < 64; o++)
          drive(o[5:0], z[0], q[0]);
    @(negedge clk);
    @(negedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule